// File: doc/BRIEF.md
# Doorbell Mailbox with Slot Rings

This block is the device-side register file of a two-party mailbox. A host reaches it through a small word-addressed register port. A peer (the other processor, or a testbench standing in for it) reaches it through a dedicated port of push, pop, ready and doorbell signals. Each direction has its own circular buffer of 32-bit slots. The host pushes slots into the host-to-peer ring and pops them from the peer-to-host ring. The peer does the opposite.

Each ring keeps 8-bit free-running read and write pointers. Its occupancy is the wrapping difference of those pointers. The pointers and the ring depth appear in a status word, next to the interrupt enable, interrupt status, doorbell, ready and reset bits. This lets host software work out filled and free slot counts from a single read. The same word carries a reset handshake: a reset request empties both rings, and the host then clears the request and declares itself ready.

Top module: `mbx_doorbell_mailbox`

## Requirements
- R1: After reset, the host status word (offset 0x04) and the peer status word (offset 0x0C) both read DEPTH in bits 31:24 and zero elsewhere, except peer-status bit 3, which follows `peer_ready`. `host_irq`, `peer_doorbell` and `mbx_reset` are 0.
- R2: A host write to offset 0x00 pushes one slot into the host-to-peer ring. A host read of offset 0x08 returns the oldest peer-to-host slot and pops it. A read of offset 0x00 returns 0, and reading either status word has no side effect. Data leaves each ring in the order it entered.
- R3: In each status word, bits 15:8 hold the read pointer and bits 23:16 the write pointer of a ring: the host word shows the host-to-peer ring and the peer word shows the peer-to-host ring. Bits 31:24 hold DEPTH. The fill count, (write − read) mod 256, never exceeds DEPTH.
- R4: Pointers count modulo 256, and storage is addressed by the pointer modulo DEPTH, so FIFO order survives the wrap of both the pointers and the storage.
- R5: A push into a full ring is dropped. The write pointer and contents stay unchanged, and the pusher's error flag is set: host-status bit 5 for the host, peer-status bit 5 for the peer.
- R6: A pop from an empty ring is dropped. The read pointer stays unchanged, the returned data is 0, and the popper's error flag (bit 5 as in R5) is set.
- R7: `peer_push` with `peer_wdata` fills the peer-to-host ring. `peer_pop` drains the host-to-peer ring, and `peer_rdata` shows its oldest slot (0 when empty). Peer-status bit 3 mirrors `peer_ready`.
- R8: A host status write with bit 2 set drives `peer_doorbell` high for exactly the next cycle. Bit 2 always reads 0.
- R9: A `peer_ring` pulse sets host-status bit 1. Writing 1 to bit 1 clears it, and a simultaneous `peer_ring` wins. Bit 0 is a stored enable, and `host_irq` is high when both bits 0 and 1 are set.
- R10: A host write of 1 to bit 5 of the host status word clears the host error flag.
- R11: Host-status bit 4 is a stored reset request, driven out on `mbx_reset`. The write that sets it clears all four pointers at once and both error flags. While the request is set, pushes and pops are ignored without error. Host-status bit 3 is a stored ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (pops when addressing 0x08) |
| hst_addr | input | 4 | Host byte offset; bits 3:2 select the word |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from the current state |
| host_irq | output | 1 | Interrupt to the host |
| peer_push | input | 1 | Peer pushes one slot into the peer-to-host ring |
| peer_wdata | input | 32 | Slot data for a peer push |
| peer_pop | input | 1 | Peer pops one slot from the host-to-peer ring |
| peer_rdata | output | 32 | Oldest host-to-peer slot, 0 when empty |
| peer_ready | input | 1 | Peer readiness level |
| peer_ring | input | 1 | Peer doorbell towards the host |
| peer_doorbell | output | 1 | One-cycle doorbell pulse towards the peer |
| mbx_reset | output | 1 | Reset request towards the peer |

## Verification
The properties assume that each strobe is a clean single-cycle level sampled at the rising edge. They also assume that the address is stable whenever a strobe is high, and that the host issues at most one access per cycle. The bench respects this by changing every input only on the falling edge and by returning each strobe to 0 one time unit after the rising edge that consumes it. Overflow, underflow and reset are exercised only through the legal ports. Each such case then becomes an observable change, or lack of change, in the status words.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int SLOT_W = 32;
  localparam int PTR_W  = 8;

  localparam logic [1:0] SEL_TX_WIN = 2'd0;
  localparam logic [1:0] SEL_HOST_ST = 2'd1;
  localparam logic [1:0] SEL_RX_WIN = 2'd2;
  localparam logic [1:0] SEL_PEER_ST = 2'd3;

  localparam int B_IE  = 0;
  localparam int B_IS  = 1;
  localparam int B_IG  = 2;
  localparam int B_RDY = 3;
  localparam int B_RST = 4;
  localparam int B_ERR = 5;
  localparam int RP_LSB  = 8;
  localparam int WP_LSB  = 16;
  localparam int DEP_LSB = 24;

  typedef struct packed {
    logic ie;
    logic is;
    logic ready;
    logic rst;
    logic err;
  } ctl_flags_t;

  function automatic logic [PTR_W-1:0] fill_count(input logic [PTR_W-1:0] wp,
                                                   input logic [PTR_W-1:0] rp);
    return wp - rp;
  endfunction

  function automatic logic [PTR_W-1:0] free_count(input logic [PTR_W-1:0] depth,
                                                   input logic [PTR_W-1:0] fill);
    return depth - fill;
  endfunction

  function automatic logic [SLOT_W-1:0] pack_status(input ctl_flags_t f,
                                                     input logic [PTR_W-1:0] rp,
                                                     input logic [PTR_W-1:0] wp,
                                                     input logic [PTR_W-1:0] depth);
    logic [SLOT_W-1:0] w;
    w = '0;
    w[B_IE]  = f.ie;
    w[B_IS]  = f.is;
    w[B_RDY] = f.ready;
    w[B_RST] = f.rst;
    w[B_ERR] = f.err;
    w[RP_LSB +: PTR_W]  = rp;
    w[WP_LSB +: PTR_W]  = wp;
    w[DEP_LSB +: PTR_W] = depth;
    return w;
  endfunction
endpackage

// File: rtl/mbx_ring.sv
`timescale 1ns/1ps
module mbx_ring
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_data,
  input  logic              pop,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [SLOT_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic              push_rej,
  output logic              pop_rej
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] DEPTH_B = PTR_W'(DEPTH);

  logic [SLOT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  fill;
  logic              push_ok;
  logic              pop_ok;

  assign fill     = fill_count(wr_ptr, rd_ptr);
  assign full     = (fill == DEPTH_B);
  assign empty    = (fill == '0);
  assign push_ok  = push & ~full & ~flush;
  assign pop_ok   = pop & ~empty & ~flush;
  assign push_rej = push & full & ~flush;
  assign pop_rej  = pop & empty & ~flush;
  assign head     = empty ? '0 : store[rd_ptr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/mbx_host_ctl.sv
`timescale 1ns/1ps
module mbx_host_ctl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_wr,
  input  logic [SLOT_W-1:0] st_wdata,
  input  logic              ring_in,
  input  logic              fault_in,
  output ctl_flags_t        flags,
  output logic              doorbell,
  output logic              flush_now
);
  logic ie_q, is_q, rdy_q, rst_q, err_q, db_q;

  assign flush_now = rst_q | (st_wr & st_wdata[B_RST]);
  assign doorbell  = db_q;
  assign flags     = '{ie: ie_q, is: is_q, ready: rdy_q, rst: rst_q, err: err_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      is_q  <= 1'b0;
      rdy_q <= 1'b0;
      rst_q <= 1'b0;
      err_q <= 1'b0;
      db_q  <= 1'b0;
    end else begin
      db_q <= st_wr & st_wdata[B_IG];
      if (st_wr) begin
        ie_q  <= st_wdata[B_IE];
        rdy_q <= st_wdata[B_RDY];
        rst_q <= st_wdata[B_RST];
      end
      if (ring_in)                       is_q <= 1'b1;
      else if (st_wr && st_wdata[B_IS])  is_q <= 1'b0;
      if (fault_in)                                           err_q <= 1'b1;
      else if ((st_wr && st_wdata[B_ERR]) || flush_now)       err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_doorbell_mailbox.sv
`timescale 1ns/1ps
module mbx_doorbell_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [3:0]        hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              host_irq,
  input  logic              peer_push,
  input  logic [31:0]       peer_wdata,
  input  logic              peer_pop,
  output logic [31:0]       peer_rdata,
  input  logic              peer_ready,
  input  logic              peer_ring,
  output logic              peer_doorbell,
  output logic              mbx_reset
);
  localparam logic [PTR_W-1:0] DEPTH_B = PTR_W'(DEPTH);

  logic [1:0] sel;
  logic host_push, host_pop, st_wr, ig_wr, flush;
  logic [PTR_W-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [SLOT_W-1:0] tx_head, rx_head;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic tx_push_rej, tx_pop_rej, rx_push_rej, rx_pop_rej;
  logic host_fault, peer_fault, peer_err_q;
  ctl_flags_t host_flags, peer_flags;

  assign sel       = hst_addr[3:2];
  assign host_push = hst_wr & (sel == SEL_TX_WIN);
  assign host_pop  = hst_rd & (sel == SEL_RX_WIN);
  assign st_wr     = hst_wr & (sel == SEL_HOST_ST);
  assign ig_wr     = st_wr & hst_wdata[B_IG];

  // host-to-peer ring
  mbx_ring #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(host_push), .push_data(hst_wdata), .pop(peer_pop),
    .rd_ptr(tx_rp), .wr_ptr(tx_wp), .head(tx_head),
    .empty(tx_empty), .full(tx_full),
    .push_rej(tx_push_rej), .pop_rej(tx_pop_rej)
  );

  // peer-to-host ring
  mbx_ring #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(peer_push), .push_data(peer_wdata), .pop(host_pop),
    .rd_ptr(rx_rp), .wr_ptr(rx_wp), .head(rx_head),
    .empty(rx_empty), .full(rx_full),
    .push_rej(rx_push_rej), .pop_rej(rx_pop_rej)
  );

  assign host_fault = tx_push_rej | rx_pop_rej;
  assign peer_fault = rx_push_rej | tx_pop_rej;

  mbx_host_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_wdata(hst_wdata),
    .ring_in(peer_ring), .fault_in(host_fault),
    .flags(host_flags), .doorbell(peer_doorbell), .flush_now(flush)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          peer_err_q <= 1'b0;
    else if (peer_fault) peer_err_q <= 1'b1;
    else if (flush)      peer_err_q <= 1'b0;
  end

  assign peer_flags = '{ie: 1'b0, is: 1'b0, ready: peer_ready, rst: 1'b0, err: peer_err_q};

  always_comb begin
    unique case (sel)
      SEL_TX_WIN:  hst_rdata = '0;
      SEL_HOST_ST: hst_rdata = pack_status(host_flags, tx_rp, tx_wp, DEPTH_B);
      SEL_RX_WIN:  hst_rdata = rx_head;
      default:     hst_rdata = pack_status(peer_flags, rx_rp, rx_wp, DEPTH_B);
    endcase
  end

  assign peer_rdata = tx_head;
  assign host_irq   = host_flags.ie & host_flags.is;
  assign mbx_reset  = host_flags.rst;
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ig_wr,
  input logic       peer_ring,
  input logic       is_flag,
  input logic       flush,
  input logic [7:0] tx_rp,
  input logic [7:0] tx_wp,
  input logic [7:0] rx_rp,
  input logic [7:0] rx_wp,
  input logic       tx_push_rej,
  input logic       rx_pop_rej,
  input logic       host_err,
  input logic       peer_doorbell
);
  initial begin
    a_r4_depth_legal: assert (DEPTH >= 2 && DEPTH <= 128 && (DEPTH & (DEPTH - 1)) == 0);
  end

  a_r3_tx_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    8'(tx_wp - tx_rp) <= 8'(DEPTH));
  a_r3_rx_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    8'(rx_wp - rx_rp) <= 8'(DEPTH));
  a_r5_full_push_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_rej |=> $stable(tx_wp));
  a_r5_full_push_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_rej |=> host_err);
  a_r6_empty_pop_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_rej |=> $stable(rx_rp));
  a_r8_doorbell_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ig_wr |=> peer_doorbell);
  a_r8_doorbell_single: assert property (@(posedge clk) disable iff (!rst_n)
    !ig_wr |=> !peer_doorbell);
  a_r9_ring_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    peer_ring |=> is_flag);
  a_r11_flush_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_rp == 8'd0 && tx_wp == 8'd0 && rx_rp == 8'd0 && rx_wp == 8'd0));
endmodule

bind mbx_doorbell_mailbox mbx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ig_wr(ig_wr), .peer_ring(peer_ring),
  .is_flag(host_flags.is), .flush(flush),
  .tx_rp(tx_rp), .tx_wp(tx_wp), .rx_rp(rx_rp), .rx_wp(rx_wp),
  .tx_push_rej(tx_push_rej), .rx_pop_rej(rx_pop_rej),
  .host_err(host_flags.err), .peer_doorbell(peer_doorbell)
);

// File: tb/mbx_doorbell_mailbox_test.sv
`timescale 1ns/1ps
module mbx_doorbell_mailbox_test;
  localparam int DEPTH = 16;
  localparam int NV = 14;
  // kind: 0 host write, 1 host read+check, 2 peer push, 3 peer pop+check
  localparam logic [69:0] VEC [NV] = '{
    {2'd1, 4'h4, 32'h0,        32'h1000_0000},
    {2'd0, 4'h0, 32'hA1A1_0001, 32'h0},
    {2'd0, 4'h0, 32'hA2A2_0002, 32'h0},
    {2'd1, 4'h4, 32'h0,        32'h1002_0000},
    {2'd3, 4'h0, 32'h0,        32'hA1A1_0001},
    {2'd1, 4'h4, 32'h0,        32'h1002_0100},
    {2'd2, 4'h0, 32'hB1B1_0011, 32'h0},
    {2'd2, 4'h0, 32'hB2B2_0022, 32'h0},
    {2'd1, 4'hC, 32'h0,        32'h1002_0008},
    {2'd1, 4'h8, 32'h0,        32'hB1B1_0011},
    {2'd1, 4'hC, 32'h0,        32'h1002_0108},
    {2'd1, 4'h8, 32'h0,        32'hB2B2_0022},
    {2'd3, 4'h0, 32'h0,        32'hA2A2_0002},
    {2'd1, 4'h4, 32'h0,        32'h1002_0200}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 0, hst_rd = 0;
  logic [3:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, hst_rdata, peer_wdata = 0, peer_rdata;
  logic host_irq, peer_push = 0, peer_pop = 0, peer_ready = 0, peer_ring = 0;
  logic peer_doorbell, mbx_reset;
  int checks = 0, errors = 0;
  bit done = 0;
  int hwp, hrp;

  always #4 clk = ~clk;

  mbx_doorbell_mailbox #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input int wp, input int rp, input logic [7:0] fl);
    return {8'(DEPTH), 8'(wp % 256), 8'(rp % 256), fl};
  endfunction

  task automatic hw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1; hst_wr = 0;
  endtask
  task automatic hr(input logic [3:0] a, input logic [31:0] e, input string r);
    @(negedge clk); hst_rd = 1; hst_addr = a; #1;
    chk(r, hst_rdata, e);
    @(posedge clk); #1; hst_rd = 0;
  endtask
  task automatic pp(input logic [31:0] d);
    @(negedge clk); peer_push = 1; peer_wdata = d;
    @(posedge clk); #1; peer_push = 0;
  endtask
  task automatic pc(input logic [31:0] e, input string r);
    @(negedge clk); peer_pop = 1; #1;
    chk(r, peer_rdata, e);
    @(posedge clk); #1; peer_pop = 0;
  endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual expired expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    hr(4'h4, 32'h1000_0000, "R1 host status");
    hr(4'hC, 32'h1000_0000, "R1 peer status");
    chk("R1 irq", {29'd0, host_irq, peer_doorbell, mbx_reset}, 32'd0);
    peer_ready = 1;
    // R2 R3 R7 table walk
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      case (v[69:68])
        2'd0: hw(v[67:64], v[63:32]);
        2'd1: hr(v[67:64], v[31:0], "R2/R3 table host read");
        2'd2: pp(v[63:32]);
        default: pc(v[31:0], "R7 table peer pop");
      endcase
    end
    hr(4'h0, 32'h0, "R2 write window reads zero");
    hwp = 2; hrp = 2;
    // R5 overflow
    for (int i = 0; i < DEPTH + 1; i++) hw(4'h0, 32'hC000_0000 + i);
    hwp += DEPTH;
    hr(4'h4, st(hwp, hrp, 8'h20), "R5 overflow status");
    hw(4'h4, 32'h20);
    hr(4'h4, st(hwp, hrp, 8'h00), "R10 error cleared");
    for (int i = 0; i < DEPTH; i++) pc(32'hC000_0000 + i, "R5 contents kept");
    hrp += DEPTH;
    // R6 underflow, peer and host side
    pc(32'h0, "R6 peer pop empty data");
    hr(4'hC, 32'h1002_0228, "R6 peer error flag");
    hr(4'h8, 32'h0, "R6 host pop empty data");
    hr(4'h4, st(hwp, hrp, 8'h20), "R6 host error flag");
    hr(4'hC, 32'h1002_0228, "R6 rx pointers held");
    hw(4'h4, 32'h20);
    // R4 wrap
    for (int i = 0; i < 232; i++) begin
      hw(4'h0, 32'h5000_0000 + i);
      pc(32'h5000_0000 + i, "R4 order");
    end
    hwp += 232; hrp += 232;
    for (int i = 0; i < 10; i++) hw(4'h0, 32'hD000_0000 + i);
    hwp += 10;
    hr(4'h4, 32'h1004_FA00, "R4 wrapped pointers");
    for (int i = 0; i < 10; i++) pc(32'hD000_0000 + i, "R4 order across wrap");
    hrp += 10;
    // R8 doorbell
    hw(4'h4, 32'h4);
    @(negedge clk); chk("R8 doorbell high", {31'd0, peer_doorbell}, 32'd1);
    @(negedge clk); chk("R8 doorbell single", {31'd0, peer_doorbell}, 32'd0);
    hr(4'h4, st(hwp, hrp, 8'h00), "R8 bit not stored");
    // R9 interrupt
    @(negedge clk); peer_ring = 1; @(posedge clk); #1; peer_ring = 0;
    hr(4'h4, st(hwp, hrp, 8'h02), "R9 status set");
    chk("R9 irq masked", {31'd0, host_irq}, 32'd0);
    hw(4'h4, 32'h1);
    @(negedge clk); chk("R9 irq enabled", {31'd0, host_irq}, 32'd1);
    hw(4'h4, 32'h3);
    hr(4'h4, st(hwp, hrp, 8'h01), "R9 w1c");
    chk("R9 irq cleared", {31'd0, host_irq}, 32'd0);
    @(negedge clk); peer_ring = 1; hst_wr = 1; hst_addr = 4'h4; hst_wdata = 32'h3;
    @(posedge clk); #1; peer_ring = 0; hst_wr = 0;
    hr(4'h4, st(hwp, hrp, 8'h03), "R9 set wins");
    hw(4'h4, 32'h2);
    // R11 reset handshake
    for (int i = 0; i < 3; i++) hw(4'h0, 32'hE000_0000 + i);
    pp(32'hF1); pp(32'hF2);
    hw(4'h4, 32'h14);
    @(negedge clk);
    chk("R11 reset out", {30'd0, mbx_reset, peer_doorbell}, 32'd3);
    hr(4'h4, 32'h1000_0010, "R11 tx flushed");
    hr(4'hC, 32'h1000_0008, "R11 rx flushed and peer error cleared");
    hw(4'h0, 32'h77);
    pc(32'h0, "R11 pop during reset");
    hr(4'h4, 32'h1000_0010, "R11 push ignored");
    hr(4'hC, 32'h1000_0008, "R11 no peer error");
    hw(4'h4, 32'h0C);
    hr(4'h4, 32'h1000_0008, "R11 ready stored");
    chk("R11 reset released", {31'd0, mbx_reset}, 32'd0);
    // R5 R7 peer overflow
    for (int i = 0; i < DEPTH + 1; i++) pp(32'h9000_0000 + i);
    hr(4'hC, 32'h1010_0028, "R7 peer overflow");
    hr(4'h8, 32'h9000_0000, "R7 first peer slot");
    finish_run();
  end
endmodule